// File: doc/BRIEF.md
# Register Initialization Op Sequencer

This block walks a range of initialization records and turns each one into writes on a register bus. A record holds a 5-bit opcode, a 32-bit target address, a word length and a 32-bit argument. The argument is either an immediate value or an offset into a data ROM. Both the record store and the data ROM sit outside the block. They are read combinationally through an index output and a data input.

A pulse on `start` makes the sequencer visit every record from `first_idx` up to `stop_idx - 1`, strictly in index order. Each opcode is folded from its chip-variant or platform-specific encoding onto a common operation. Records meant for another variant or platform are dropped. Surviving records are carried out as single writes, string copies, zero fills or two-word pattern fills, with each transfer cut into bursts of bounded length.

The write port is a valid/ready handshake. When the range has been walked, `done` pulses for one cycle.

Top module: `opseq_sequencer`

## Requirements
- R1: Synchronous active-high reset. In the cycle after reset, `wr_valid` and `done` are 0.
- R2: Records from `first_idx` to `stop_idx - 1` are processed in ascending index order. The bus writes appear in record order. `first_idx >= stop_idx` processes nothing.
- R3: Common opcodes 2 and 3 issue one write of the argument to the record address. Opcodes 0, 1 and 7 cause no bus activity.
- R4: Opcodes 0x0A..0x12 are reduced by 9 to the common set when `chip_sel` is 0 (first variant). When `chip_sel` is 1 they are skipped.
- R5: Opcodes 0x13..0x1B are reduced by 0x12 to the common set when `chip_sel` is 1 (second variant). When `chip_sel` is 0 they are skipped.
- R6: Opcodes 0x1C..0x1F are single writes. The encoding of `plat_sel` is 0 ASIC, 1 FPGA, 2 emulation and 3 reserved. Each opcode is enabled as follows:
  - 0x1C: second variant on emulation.
  - 0x1D: emulation.
  - 0x1E: FPGA.
  - 0x1F: ASIC.
  Otherwise the record is skipped.
- R7: Opcodes 4, 5 and 9 copy `len` words. Word i comes from data ROM entry (arg[7:0] + i) mod 256 and goes to address addr + 4·i.
- R8: Opcode 6 writes `len` all-zero words at addr + 4·i.
- R9: Opcode 8 repeats a 64-bit pattern across `len` words. Even words take data entry arg[7:0] (the low half). Odd words take entry arg[7:0] + 1 (the high half).
- R10: `wr_burst_first` is high on word i of a transfer exactly when i mod MAX_BURST is 0. A single write is a one-word burst.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R12: A skipped record, or a record of zero length, takes one cycle with no bus activity. After the start edge, a run of k such records raises `done` k+1 edges later.
- R13: `done` is high for exactly one cycle per run, after the last write has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (ignored while busy) |
| first_idx | input | IDX_W | First record index |
| stop_idx | input | IDX_W | Index one past the last record |
| chip_sel | input | 1 | 0 first chip variant, 1 second |
| plat_sel | input | 2 | Platform strap: 0 ASIC, 1 FPGA, 2 emulation |
| rec_idx | output | IDX_W | Record store read index |
| rec_opcode | input | 5 | Record opcode |
| rec_addr | input | 32 | Record target byte address |
| rec_len | input | LEN_W | Record length in 32-bit words |
| rec_arg | input | 32 | Immediate value or data offset |
| dat_idx | output | DOFF_W | Data ROM read index |
| dat_word | input | 32 | Data ROM word |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| wr_burst_first | output | 1 | First word of a burst |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench targets the following corner cases:
- Opcodes on the edges of each variant range under both variant straps. A wrong fold offset writes the wrong kind of data, or leaves a foreign record unskipped.
- String lengths of exact multiples of the burst length, and lengths just past them. An off-by-one burst counter moves or drops the burst-start flag.
- Pattern fills of odd length. Swapping the low and high halves shows up on the very first word.
- Random back-pressure. A sequencer that advances without a handshake loses or repeats words.
- Runs made only of skipped records, and empty ranges. These expose extra or missing cycles before `done`.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

    localparam int OPC_W = 5;

    typedef enum logic [1:0] {
        XK_SINGLE  = 2'd0,
        XK_STRING  = 2'd1,
        XK_ZERO    = 2'd2,
        XK_PATTERN = 2'd3
    } xfer_kind_e;

    typedef enum logic [1:0] {
        PF_ASIC = 2'd0,
        PF_FPGA = 2'd1,
        PF_EMUL = 2'd2,
        PF_RSVD = 2'd3
    } platform_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_XFER  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic       ok;
        logic [3:0] base;
    } fold_t;

    typedef struct packed {
        logic       run;
        xfer_kind_e kind;
    } op_action_t;

    // Map a variant/platform opcode onto the common 1..9 set.
    function automatic fold_t fold_opcode(logic [OPC_W-1:0] op,
                                          logic variant_b,
                                          platform_e plat);
        fold_t          f;
        logic [OPC_W-1:0] t;
        f = '{ok: 1'b0, base: 4'd0};
        t = '0;
        if (op >= 5'h01 && op <= 5'h09) begin
            f.ok   = 1'b1;
            f.base = op[3:0];
        end else if (op >= 5'h0A && op <= 5'h12) begin
            t      = op - 5'd9;
            f.ok   = !variant_b;
            f.base = t[3:0];
        end else if (op >= 5'h13 && op <= 5'h1B) begin
            t      = op - 5'h12;
            f.ok   = variant_b;
            f.base = t[3:0];
        end else begin
            f.base = 4'd2;
            case (op)
                5'h1C:   f.ok = variant_b && (plat == PF_EMUL);
                5'h1D:   f.ok = (plat == PF_EMUL);
                5'h1E:   f.ok = (plat == PF_FPGA);
                5'h1F:   f.ok = (plat == PF_ASIC);
                default: f.ok = 1'b0;
            endcase
        end
        return f;
    endfunction

    // Common operation to transfer kind; reads and compressed copies are dropped.
    function automatic op_action_t classify(logic [3:0] base);
        op_action_t a;
        a = '{run: 1'b0, kind: XK_SINGLE};
        case (base)
            4'd2, 4'd3:       a = '{run: 1'b1, kind: XK_SINGLE};
            4'd4, 4'd5, 4'd9: a = '{run: 1'b1, kind: XK_STRING};
            4'd6:             a = '{run: 1'b1, kind: XK_ZERO};
            4'd8:             a = '{run: 1'b1, kind: XK_PATTERN};
            default:          a = '{run: 1'b0, kind: XK_SINGLE};
        endcase
        return a;
    endfunction

endpackage

// File: rtl/opseq_decode.sv
module opseq_decode
    import opseq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic             variant_b,
    input  logic [1:0]       plat,
    output op_action_t       act
);
    fold_t folded;

    always_comb begin
        folded = fold_opcode(opcode, variant_b, platform_e'(plat));
        act    = classify(folded.base);
        if (!folded.ok) begin
            act.run = 1'b0;
        end
    end
endmodule

// File: rtl/opseq_words.sv
module opseq_words #(
    parameter int LEN_W     = 8,
    parameter int MAX_BURST = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    input  logic             step,
    output logic [LEN_W-1:0] word,
    output logic             last,
    output logic             burst_first
);
    localparam int BC_W = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;
    localparam logic [BC_W-1:0] BC_TOP = BC_W'(MAX_BURST - 1);

    logic [LEN_W-1:0] len_q;
    logic [BC_W-1:0]  bcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            word  <= '0;
            bcnt  <= '0;
        end else if (load) begin
            len_q <= len_in;
            word  <= '0;
            bcnt  <= '0;
        end else if (step) begin
            word <= word + LEN_W'(1);
            bcnt <= (bcnt == BC_TOP) ? '0 : bcnt + BC_W'(1);
        end
    end

    assign last        = (word == len_q - LEN_W'(1));
    assign burst_first = (bcnt == '0);

    a_r10_burst_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && !last && !load && bcnt == BC_TOP) |=> burst_first);

    a_r10_burst_inner: assert property (@(posedge clk) disable iff (rst)
        (step && !last && !load && bcnt != BC_TOP) |=> !burst_first);
endmodule

// File: rtl/opseq_wdata.sv
module opseq_wdata
    import opseq_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int DOFF_W = 8
) (
    input  xfer_kind_e        kind,
    input  logic [31:0]       arg,
    input  logic [LEN_W-1:0]  word,
    input  logic [31:0]       dat_word,
    output logic [DOFF_W-1:0] dat_idx,
    output logic [31:0]       wdata
);
    always_comb begin
        if (kind == XK_PATTERN) begin
            dat_idx = arg[DOFF_W-1:0] + DOFF_W'(word[0]);
        end else begin
            dat_idx = arg[DOFF_W-1:0] + DOFF_W'(word);
        end
        case (kind)
            XK_SINGLE: wdata = arg;
            XK_ZERO:   wdata = '0;
            default:   wdata = dat_word;
        endcase
    end
endmodule

// File: rtl/opseq_sequencer.sv
module opseq_sequencer
    import opseq_pkg::*;
#(
    parameter int IDX_W     = 6,
    parameter int LEN_W     = 8,
    parameter int DOFF_W    = 8,
    parameter int MAX_BURST = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  first_idx,
    input  logic [IDX_W-1:0]  stop_idx,
    input  logic              chip_sel,
    input  logic [1:0]        plat_sel,
    output logic [IDX_W-1:0]  rec_idx,
    input  logic [4:0]        rec_opcode,
    input  logic [31:0]       rec_addr,
    input  logic [LEN_W-1:0]  rec_len,
    input  logic [31:0]       rec_arg,
    output logic [DOFF_W-1:0] dat_idx,
    input  logic [31:0]       dat_word,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [31:0]       wr_addr,
    output logic [31:0]       wr_data,
    output logic              wr_burst_first,
    output logic              done
);
    localparam logic [LEN_W-1:0] ONE_WORD = LEN_W'(1);

    seq_state_e       state;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] stop_q;
    logic [31:0]      base_q;
    logic [31:0]      arg_q;
    xfer_kind_e       kind_q;
    op_action_t       act;
    logic [LEN_W-1:0] eff_len;
    logic             in_range;
    logic             launch;
    logic             fire;
    logic [LEN_W-1:0] word;
    logic             last;

    opseq_decode u_decode (
        .opcode    (rec_opcode),
        .variant_b (chip_sel),
        .plat      (plat_sel),
        .act       (act)
    );

    assign in_range = (cur_idx < stop_q);
    assign eff_len  = (act.kind == XK_SINGLE) ? ONE_WORD : rec_len;
    assign launch   = (state == ST_FETCH) && in_range && act.run && (eff_len != '0);
    assign fire     = wr_valid && wr_ready;

    opseq_words #(
        .LEN_W     (LEN_W),
        .MAX_BURST (MAX_BURST)
    ) u_words (
        .clk         (clk),
        .rst         (rst),
        .load        (launch),
        .len_in      (eff_len),
        .step        (fire),
        .word        (word),
        .last        (last),
        .burst_first (wr_burst_first)
    );

    opseq_wdata #(
        .LEN_W  (LEN_W),
        .DOFF_W (DOFF_W)
    ) u_wdata (
        .kind     (kind_q),
        .arg      (arg_q),
        .word     (word),
        .dat_word (dat_word),
        .dat_idx  (dat_idx),
        .wdata    (wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cur_idx <= '0;
            stop_q  <= '0;
            base_q  <= '0;
            arg_q   <= '0;
            kind_q  <= XK_SINGLE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cur_idx <= first_idx;
                        stop_q  <= stop_idx;
                        state   <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (!in_range) begin
                        state <= ST_DONE;
                    end else if (launch) begin
                        base_q <= rec_addr;
                        arg_q  <= rec_arg;
                        kind_q <= act.kind;
                        state  <= ST_XFER;
                    end else begin
                        cur_idx <= cur_idx + IDX_W'(1);
                    end
                end
                ST_XFER: begin
                    if (fire && last) begin
                        cur_idx <= cur_idx + IDX_W'(1);
                        state   <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rec_idx  = cur_idx;
    assign wr_valid = (state == ST_XFER);
    assign wr_addr  = base_q + (32'(word) << 2);
    assign done     = (state == ST_DONE);

    a_r11_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    a_r13_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r4_foreign_variant: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH && in_range && chip_sel &&
         rec_opcode >= 5'h0A && rec_opcode <= 5'h12) |=> !wr_valid);

    a_r6_platform_skip: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH && in_range && rec_opcode == 5'h1F &&
         plat_sel != 2'd0) |=> !wr_valid);
endmodule

// File: tb/opseq_sequencer_tb.sv
module opseq_sequencer_tb_top;
    localparam int IDX_W = 6, LEN_W = 8, DOFF_W = 8, MAXB = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [IDX_W-1:0] first_idx = '0, stop_idx = '0;
    logic chip_sel = 1'b0;
    logic [1:0] plat_sel = 2'd0;
    logic [IDX_W-1:0] rec_idx;
    logic [DOFF_W-1:0] dat_idx;
    logic wr_valid, wr_ready = 1'b0, wr_burst_first, done;
    logic [31:0] wr_addr, wr_data;

    logic [4:0]       r_op   [64];
    logic [31:0]      r_addr [64];
    logic [LEN_W-1:0] r_len  [64];
    logic [31:0]      r_arg  [64];
    logic [31:0]      dmem   [256];

    wire [4:0]       rec_opcode = r_op[rec_idx];
    wire [31:0]      rec_addr   = r_addr[rec_idx];
    wire [LEN_W-1:0] rec_len    = r_len[rec_idx];
    wire [31:0]      rec_arg    = r_arg[rec_idx];
    wire [31:0]      dat_word   = dmem[dat_idx];

    always #10 clk = ~clk;

    opseq_sequencer #(.IDX_W(IDX_W), .LEN_W(LEN_W), .DOFF_W(DOFF_W), .MAX_BURST(MAXB)) dut_i (
        .clk(clk), .rst(rst), .start(start), .first_idx(first_idx), .stop_idx(stop_idx),
        .chip_sel(chip_sel), .plat_sel(plat_sel), .rec_idx(rec_idx), .rec_opcode(rec_opcode),
        .rec_addr(rec_addr), .rec_len(rec_len), .rec_arg(rec_arg), .dat_idx(dat_idx),
        .dat_word(dat_word), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_burst_first(wr_burst_first), .done(done));

    int checks = 0, errors = 0;
    bit finished = 0;
    bit logging = 0;
    int stall_pct = 0;

    logic [31:0] exp_addr[$], exp_data[$], got_addr[$], got_data[$];
    bit exp_bf[$], got_bf[$];
    string exp_tag[$];

    task automatic check(bit ok, string tag, string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // -1 skip, 0 single, 1 string, 2 zero, 3 pattern
    function automatic int ref_kind(int op, bit vb, int plat);
        int b;
        bit ok;
        if (op >= 1 && op <= 9) begin b = op; ok = 1; end
        else if (op >= 10 && op <= 18) begin b = op - 9; ok = !vb; end
        else if (op >= 19 && op <= 27) begin b = op - 18; ok = vb; end
        else if (op == 28) return (vb && plat == 2) ? 0 : -1;
        else if (op == 29) return (plat == 2) ? 0 : -1;
        else if (op == 30) return (plat == 1) ? 0 : -1;
        else if (op == 31) return (plat == 0) ? 0 : -1;
        else return -1;
        if (!ok) return -1;
        if (b == 2 || b == 3) return 0;
        if (b == 4 || b == 5 || b == 9) return 1;
        if (b == 6) return 2;
        if (b == 8) return 3;
        return -1;
    endfunction

    function automatic string tag_of(int op, int k);
        if (op >= 28) return "R6";
        if (op >= 19) return "R5";
        if (op >= 10) return "R4";
        if (k == 0) return "R3";
        if (k == 1) return "R7";
        if (k == 2) return "R8";
        return "R9";
    endfunction

    task automatic build_expected(int first, int stop, bit vb, int plat);
        exp_addr.delete(); exp_data.delete(); exp_bf.delete(); exp_tag.delete();
        for (int i = first; i < stop; i++) begin
            int k = ref_kind(int'(r_op[i]), vb, plat);
            int n;
            if (k < 0) continue;
            n = (k == 0) ? 1 : int'(r_len[i]);
            for (int w = 0; w < n; w++) begin
                logic [7:0] di;
                logic [31:0] d;
                di = (k == 3) ? 8'(r_arg[i][7:0] + 8'(w % 2)) : 8'(r_arg[i][7:0] + 8'(w));
                case (k)
                    0: d = r_arg[i];
                    2: d = 32'd0;
                    default: d = dmem[di];
                endcase
                exp_addr.push_back(r_addr[i] + 32'(4 * w));
                exp_data.push_back(d);
                exp_bf.push_back((w % MAXB) == 0);
                exp_tag.push_back(tag_of(int'(r_op[i]), k));
            end
        end
    endtask

    task automatic run_seq(int first, int stop, bit vb, int plat, int stall, output int cyc);
        int dones = 0;
        build_expected(first, stop, vb, plat);
        got_addr.delete(); got_data.delete(); got_bf.delete();
        chip_sel = vb; plat_sel = 2'(plat);
        first_idx = IDX_W'(first); stop_idx = IDX_W'(stop);
        stall_pct = stall;
        logging = 1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        for (int t = 0; t < 5000; t++) begin
            @(negedge clk); #2;
            cyc++;
            if (done) begin dones++; break; end
        end
        for (int t = 0; t < 3; t++) begin
            @(negedge clk); #2;
            if (done) dones++;
        end
        logging = 0;
        check(dones == 1, "R13", $sformatf("done pulses %0d expected 1", dones));
        check(got_addr.size() == exp_addr.size(), "R2",
              $sformatf("write count %0d expected %0d", got_addr.size(), exp_addr.size()));
        for (int i = 0; i < exp_addr.size() && i < got_addr.size(); i++) begin
            check(got_bf[i] == exp_bf[i], "R10",
                  $sformatf("word %0d burst_first %0b expected %0b", i, got_bf[i], exp_bf[i]));
            check(got_addr[i] == exp_addr[i] && got_data[i] == exp_data[i], exp_tag[i],
                  $sformatf("word %0d addr %h data %h expected addr %h data %h",
                            i, got_addr[i], got_data[i], exp_addr[i], exp_data[i]));
        end
    endtask

    // Ready driver and write monitor; also checks hold during stalls (R11).
    initial begin
        bit prev_stall = 0;
        logic [31:0] pa = '0, pd = '0;
        forever begin
            @(negedge clk);
            wr_ready = ($urandom_range(0, 99) >= stall_pct);
            #1;
            if (logging) begin
                if (prev_stall)
                    check(wr_valid && wr_addr == pa && wr_data == pd, "R11",
                          $sformatf("after stall valid %0b addr %h data %h expected 1 %h %h",
                                    wr_valid, wr_addr, wr_data, pa, pd));
                if (wr_valid && wr_ready) begin
                    got_addr.push_back(wr_addr);
                    got_data.push_back(wr_data);
                    got_bf.push_back(wr_burst_first);
                end
                prev_stall = wr_valid && !wr_ready;
                pa = wr_addr; pd = wr_data;
            end else begin
                prev_stall = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic set_rec(int i, int op, logic [31:0] a, int len, logic [31:0] arg);
        r_op[i] = 5'(op); r_addr[i] = a; r_len[i] = LEN_W'(len); r_arg[i] = arg;
    endtask

    initial begin
        int cyc;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) dmem[i] = $urandom();
        for (int i = 0; i < 64; i++) set_rec(i, 0, 32'h0, 0, 32'h0);

        // Directed table
        set_rec(0, 2,    32'h0000_1000, 3,  32'hDEAD_BEEF);
        set_rec(1, 5'h0B, 32'h0000_1004, 0, 32'h1234_5678);
        set_rec(2, 5'h14, 32'h0000_1008, 0, 32'hCAFE_0001);
        set_rec(3, 4,    32'h0000_2000, 10, 32'h0000_0010);
        set_rec(4, 5'h0F, 32'h0000_3000, 5, 32'h0);
        set_rec(5, 8,    32'h0000_4000, 7, 32'h0000_0040);
        set_rec(6, 5'h1F, 32'h0000_5000, 1, 32'hA51C_0001);
        set_rec(7, 5'h1E, 32'h0000_5004, 1, 32'hA51C_0002);
        set_rec(8, 1,    32'h0000_5008, 1, 32'h0);
        set_rec(9, 5'h1C, 32'h0000_500C, 1, 32'hA51C_0003);
        set_rec(10, 5'h1D, 32'h0000_5010, 1, 32'hA51C_0004);
        set_rec(11, 5'h19, 32'h0000_6000, 8, 32'h0000_00FE);
        set_rec(12, 5'h17, 32'h0000_7000, 4, 32'h0000_0080);
        set_rec(13, 4,    32'h0000_8000, 0, 32'h0);
        for (int i = 20; i < 26; i++) set_rec(i, 5'h1E, 32'h100 * i, 2, 32'h0);

        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk); #2;
        check(!wr_valid && !done, "R1",
              $sformatf("after reset valid %0b done %0b expected 0 0", wr_valid, done));

        run_seq(0, 14, 1'b0, 0, 0, cyc);
        run_seq(0, 14, 1'b1, 2, 0, cyc);
        run_seq(0, 14, 1'b0, 1, 50, cyc);
        run_seq(0, 14, 1'b1, 0, 60, cyc);

        run_seq(20, 26, 1'b0, 0, 0, cyc);
        check(cyc == 7, "R12", $sformatf("skip-only run done after %0d edges expected 7", cyc));
        run_seq(5, 5, 1'b1, 2, 0, cyc);
        check(cyc == 1, "R2", $sformatf("empty range done after %0d edges expected 1", cyc));
        run_seq(9, 2, 1'b0, 0, 0, cyc);
        check(cyc == 1, "R2", $sformatf("reversed range done after %0d edges expected 1", cyc));

        for (int i = 32; i < 64; i++)
            set_rec(i, $urandom_range(0, 31), $urandom() & 32'hFFFF_FFFC,
                    $urandom_range(0, 11), $urandom());
        for (int r = 0; r < 8; r++) begin
            int f = $urandom_range(32, 50);
            int s = $urandom_range(f, 63);
            run_seq(f, s, 1'($urandom_range(0, 1)), $urandom_range(0, 3), 40, cyc);
        end

        finish_run();
    end
endmodule